// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block produces one or two pulse-width modulated outputs from a single input clock. Each channel divides the clock by a programmable prescale factor and then counts prescaled steps through a programmable period. The output is high for the first part of each period, and the duty value sets how long that part lasts. A flag can force the output high for the whole period. Software programs each channel through a word-wide register bus. The second channel's registers sit 0x10 above the first channel's.

Writes land in shadow registers. A running channel copies the shadow values into its working set only when a period ends, so reprogramming never produces a truncated or stretched pulse. Each channel has its own enable input. When the enable drops, a shutdown-mode bit in the control register selects one of two behaviours: the channel either completes the current period or cuts the output at once.

Top module: `pwm_prescaled`

## Requirements
- R1: While enabled, a channel's output repeats with a period of exactly (PS+1)*(PV+1) clock cycles. PS is the 6-bit prescale field and PV is the 10-bit period field.
- R2: Each period starts with the output high for (PS+1)*DC cycles, then the output is low for the rest of the period. DC is the 10-bit duty field.
- R3: If DC is 0 and the full-duty flag is clear, the output stays low. If DC is greater than PV and the flag is clear, the output stays high for the whole period.
- R4: When the full-duty flag (duty register bit 10) is set, the output is high for the entire period whatever the DC value.
- R5: The registers are word-aligned. Offset 0x00 is control, with PS in bits 5:0 and the shutdown-mode bit in bit 6. Offset 0x04 is duty, with DC in bits 9:0 and the full-duty flag in bit 10. Offset 0x08 is period, with PV in bits 9:0. Reads return the stored fields with all other bits zero. Unmapped or non-word-aligned addresses read as zero and ignore writes.
- R6: When the build parameter selects two channels, channel 1 uses the same layout at offsets 0x10, 0x14 and 0x18. Channel 1 runs independently of channel 0.
- R7: A register write made while a channel runs does not change the current period. It takes effect from the next period boundary.
- R8: If the enable drops while the shutdown-mode bit is clear, the current period completes unchanged and the output then stays low.
- R9: If the enable drops while the shutdown-mode bit is set, the output is low from the next cycle and the counters return to zero.
- R10: After reset, or while a channel is idle, its output is low and its counters hold zero. When the enable rises, a fresh period starts on the next cycle using the shadow values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| en_i | input | NUM_CH | Enable, one bit per channel |
| pwm_o | output | NUM_CH | Modulated output, one bit per channel |

## Verification
On every cycle the assertions check three things: that the prescale and period counters stay within their programmed limits, that the working values change only at a period boundary, and that an idle channel holds zeroed counters. They also check that a disable in shutdown mode clears the output on the following cycle. Only the bench scenarios can show the exact waveform shape. This covers the period and high-time lengths, the zero and over-range duty cases, the full-duty flag, the drain-to-boundary disable, and the deferred effect of a write made mid-period. Register decode and independence between the two channels are likewise checked only by the scenarios.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PS_W = 6;
  localparam int PV_W = 10;

  typedef struct packed {
    logic            sd;
    logic [PS_W-1:0] ps;
    logic            fd;
    logic [PV_W-1:0] dc;
    logic [PV_W-1:0] pv;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output chan_cfg_t         cfg_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int SD_BIT = PS_W;
  localparam int FD_BIT = PV_W;

  chan_cfg_t cfg_q;
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:FD_BIT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        2'd0: begin
          cfg_q.ps <= wdata_i[PS_W-1:0];
          cfg_q.sd <= wdata_i[SD_BIT];
        end
        2'd1: begin
          cfg_q.dc <= wdata_i[PV_W-1:0];
          cfg_q.fd <= wdata_i[FD_BIT];
        end
        2'd2: cfg_q.pv <= wdata_i[PV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      2'd0: begin
        rdata_o[PS_W-1:0] = cfg_q.ps;
        rdata_o[SD_BIT]   = cfg_q.sd;
      end
      2'd1: begin
        rdata_o[PV_W-1:0] = cfg_q.dc;
        rdata_o[FD_BIT]   = cfg_q.fd;
      end
      2'd2: rdata_o[PV_W-1:0] = cfg_q.pv;
      default: ;
    endcase
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  chan_cfg_t cfg_i,
  output logic      pwm_o
);
  logic            run_q;
  logic [PS_W-1:0] pre_q, act_ps;
  logic [PV_W-1:0] per_q, act_dc, act_pv;
  logic            act_fd;
  logic            pre_end, per_end;

  assign pre_end = (pre_q == act_ps);
  assign per_end = (per_q == act_pv);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      per_q  <= '0;
      act_ps <= '0;
      act_dc <= '0;
      act_pv <= '0;
      act_fd <= 1'b0;
    end else if (!run_q) begin
      pre_q <= '0;
      per_q <= '0;
      if (en_i) begin
        run_q  <= 1'b1;
        act_ps <= cfg_i.ps;
        act_dc <= cfg_i.dc;
        act_pv <= cfg_i.pv;
        act_fd <= cfg_i.fd;
      end
    end else if (!en_i && cfg_i.sd) begin
      // shutdown mode: cut immediately
      run_q <= 1'b0;
      pre_q <= '0;
      per_q <= '0;
    end else if (pre_end) begin
      pre_q <= '0;
      if (per_end) begin
        per_q  <= '0;
        act_ps <= cfg_i.ps;
        act_dc <= cfg_i.dc;
        act_pv <= cfg_i.pv;
        act_fd <= cfg_i.fd;
        if (!en_i) run_q <= 1'b0;
      end else begin
        per_q <= per_q + 1'b1;
      end
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign pwm_o = run_q & (act_fd | (per_q < act_dc));

  AST_SD_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && cfg_i.sd) |=> !pwm_o);                                   // R9
  AST_PRE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (pre_q <= act_ps));                                      // R1
  AST_PER_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (per_q <= act_pv));                                      // R1
  AST_HOLD_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !(pre_end && per_end)) |=>
      ($stable(act_dc) && $stable(act_pv) && $stable(act_ps) && $stable(act_fd))); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (pre_q == '0 && per_q == '0));                          // R10
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam int CH_LSB = 4;  // 0x10 stride per channel
  localparam int CH_W   = ADDR_W - CH_LSB;

  logic            word_ok;
  logic [1:0]      sel;
  logic [CH_W-1:0] ch_idx;
  logic [DATA_W-1:0] rd [NUM_CH];

  assign word_ok = (bus_addr_i[1:0] == 2'b00);
  assign sel     = bus_addr_i[3:2];
  assign ch_idx  = bus_addr_i[ADDR_W-1:CH_LSB];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_cfg_t cfg;
    logic      hit;
    assign hit = word_ok && (ch_idx == CH_W'(c));

    pwm_shadow #(.DATA_W(DATA_W)) u_shadow (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bus_we_i && hit),
      .sel_i   (sel),
      .wdata_i (bus_wdata_i),
      .cfg_o   (cfg),
      .rdata_o (rd[c])
    );

    pwm_core u_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i[c]),
      .cfg_i  (cfg),
      .pwm_o  (pwm_o[c])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (word_ok && ch_idx == CH_W'(c)) bus_rdata_o = rd[c];
    end
  end
endmodule

// File: tb/pwm_prescaled_tb.sv
`timescale 1ns/1ps
module pwm_prescaled_tb;
  localparam int NUM_CH = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NUM_CH-1:0] en = '0;
  logic [NUM_CH-1:0] pwm;

  int checks = 0;
  int failures = 0;
  logic [NUM_CH-1:0] exp_q[$];
  string             tag_q[$];

  always #10 clk = ~clk;

  pwm_prescaled #(.NUM_CH(NUM_CH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .en_i(en), .pwm_o(pwm)
  );

  // monitor: one expected item per cycle after each edge
  initial forever begin
    @(posedge clk); #5;
    if (exp_q.size() > 0) begin
      logic [NUM_CH-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pwm !== e) begin
        failures++;
        $display("FAIL %s pwm actual=%b expected=%b at %0t", t, pwm, e, $time);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic push(input logic [NUM_CH-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string t);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== e) begin
      failures++;
      $display("FAIL %s read @%h actual=%h expected=%h", t, a, bus_rdata, e);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic wave_bit(int i, int ps, int dc, int fd, int pv);
    int l = (ps + 1) * (pv + 1);
    int pos = i % l;
    return (fd != 0) || ((pos / (ps + 1)) < dc);
  endfunction

  // program channel, enable, drop enable after k cycles, expect waveform
  task automatic run_wave(input int ch, input int ps, input int dc, input int fd,
                          input int pv, input int sd, input int k, input string t);
    int l = (ps + 1) * (pv + 1);
    int n;
    logic [4:0] base = (ch == 1) ? 5'h10 : 5'h00;
    wr(base + 5'h0, 32'((sd << 6) | ps));
    wr(base + 5'h4, 32'((fd << 10) | dc));
    wr(base + 5'h8, 32'(pv));
    n = (sd != 0) ? k : ((k + l - 1) / l) * l;
    en[ch] = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [NUM_CH-1:0] e = '0;
      e[ch] = wave_bit(i, ps, dc, fd, pv);
      push(e, t);
    end
    for (int i = 0; i < 3; i++) push('0, t);
    repeat (k) @(negedge clk);
    en[ch] = 1'b0;
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (pwm !== '0) begin
      failures++;
      $display("FAIL R10 reset pwm actual=%b expected=00", pwm);
    end
    rd_chk(5'h04, 32'h0, "R10");
    rst_ni = 1'b1;
    @(negedge clk);

    // R5: register fields and decode
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h08, 32'hFFFF_FFFF);
    rd_chk(5'h00, 32'h7F, "R5");
    rd_chk(5'h04, 32'h7FF, "R5");
    rd_chk(5'h08, 32'h3FF, "R5");
    rd_chk(5'h0C, 32'h0, "R5");
    rd_chk(5'h01, 32'h0, "R5");
    wr(5'h05, 32'h0);               // misaligned: ignored
    rd_chk(5'h04, 32'h7FF, "R5");
    // R6: channel 1 independent registers
    rd_chk(5'h18, 32'h0, "R6");
    wr(5'h18, 32'h155);
    rd_chk(5'h18, 32'h155, "R6");
    rd_chk(5'h08, 32'h3FF, "R6");

    run_wave(0, 1, 2, 0, 4, 0, 20, "R1_R2");  // 10-cycle period, 4 high
    run_wave(0, 2, 1, 0, 1, 0, 6, "R1_R2");   // 6-cycle period, 3 high
    run_wave(0, 0, 0, 0, 3, 0, 4, "R3");      // DC=0: low
    run_wave(0, 0, 9, 0, 3, 0, 4, "R3");      // DC>PV: high
    run_wave(0, 2, 1, 1, 2, 0, 9, "R4");      // full-duty flag
    run_wave(0, 0, 3, 0, 5, 0, 2, "R8");      // drain to boundary
    run_wave(0, 0, 3, 0, 5, 1, 2, "R9");      // immediate cut
    run_wave(1, 0, 1, 0, 1, 0, 4, "R6");      // channel 1 alone

    // R7: duty change mid-period applies next period
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h1);
    wr(5'h08, 32'h3);
    en[0] = 1'b1;
    push(2'b01, "R7"); push(2'b00, "R7"); push(2'b00, "R7"); push(2'b00, "R7");
    push(2'b01, "R7"); push(2'b01, "R7"); push(2'b01, "R7"); push(2'b00, "R7");
    push(2'b00, "R7"); push(2'b00, "R7");
    repeat (2) @(negedge clk);
    wr(5'h04, 32'h3);
    repeat (5) @(negedge clk);
    en[0] = 1'b0;
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule